// File: doc/BRIEF.md
# Audio Serial Clock Fault Monitor

This block watches the bit clock and frame sync of an audio serial port, using a free-running reference clock. Three clock-health checks run side by side. The first counts bit clocks per frame and accepts only a fixed set of ratios. The second measures the frame period in reference cycles against a programmable window. The third times how long each clock has gone without an edge and compares that with a programmable limit. These checks exist to catch a host that stops, glitches or misprograms its audio clocks while recording.

While any check reports a fault, the monitor forces the record channels into shutdown. The channel gain drops to full mute on the next reference clock edge. Once every fault has cleared, the gain climbs back toward the stored target setting, one 0.5 dB code step per frame. A fault that arrives during this climb sends the gain straight back to mute. The monitor also produces a one-cycle event for an interrupt controller, and a sticky status bit that the host clears.

Bit clocks are counted in the bit-clock domain. The count for each frame is handed to the reference domain through a toggle handshake. Both serial clocks are also brought into the reference domain through two-stage synchronisers, where edges are detected.

Top module: `asi_clk_fault_mon`

## Requirements
- R1: `fault_cause[1]` (ratio fault) is set after a frame whose bit-clock count is not one of 32, 48, 64, 96, 128, 192, 256, 384 or 512. It is cleared after a frame whose count is one of those values. The first partial frame after reset is never judged.
- R2: `fault_cause[0]` (rate fault) is set when the number of reference cycles between two frame-sync rising edges is below `per_min` or above `per_max`. A measurement inside that window clears it.
- R3: `fault_cause[2]` (pause fault) is high while either serial clock has gone `pause_limit` or more reference cycles without an edge. It drops once both clocks toggle again.
- R4: `fault` is the OR of the three cause bits and `chan_mute` follows it. On the cycle after `fault` is high, `gain_out` is 0, including when a recovery ramp is in progress.
- R5: With no fault present and `gain_out` below `gain_target`, `gain_out` rises by exactly one code per frame-sync rising edge. It never rises by more than one in a single cycle. `ramping` is high during this climb.
- R6: With no fault present and `gain_out` above `gain_target`, `gain_out` equals `gain_target` one cycle later.
- R7: `fault_irq` is a one-cycle pulse, issued the cycle after `fault` rises.
- R8: `fault_stat` is set whenever `fault` is high. If `stat_clr` is asserted while `fault` is low, `fault_stat` is cleared. If `stat_clr` is asserted while `fault` is high, `fault_stat` stays set.
- R9: After reset, `gain_out`, `fault_cause`, `fault`, `fault_irq` and `fault_stat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| fsync | input | 1 | Serial frame sync, rising edge starts a frame |
| pause_limit | input | TMR_W | Idle limit in reference cycles for either clock |
| per_min | input | TMR_W | Shortest allowed frame period, reference cycles |
| per_max | input | TMR_W | Longest allowed frame period, reference cycles |
| gain_target | input | GAIN_W | Stored channel gain code, 0.5 dB per step above mute |
| stat_clr | input | 1 | Clear request for the sticky status bit |
| fault_cause | output | 3 | Live fault causes: bit 2 pause, bit 1 ratio, bit 0 rate |
| fault | output | 1 | Any fault present |
| chan_mute | output | 1 | Record channel shutdown request |
| fault_irq | output | 1 | One-cycle fault event for the interrupt block |
| fault_stat | output | 1 | Sticky fault status |
| gain_out | output | GAIN_W | Current channel gain code |
| ramping | output | 1 | Recovery ramp in progress |

## Verification
The checks are driven by frame streams with different bit-clock ratios and bit-clock speeds. Some streams have a valid ratio but a frame period outside the window, which separates the rate check from the ratio check. One stream has a ratio of 100 with an in-range period, which trips only the ratio check. A clock halt is checked twice: once just short of the idle limit and once just past it, which tests the pause threshold on both sides. A fault injected partway through a recovery ramp shows that muting takes priority over the climb, and lowering the target shows that a downward change in gain is applied at once.

// File: rtl/asi_clk_fault_mon.sv
module asi_clk_fault_mon #(
  parameter int CNT_W  = 10,
  parameter int TMR_W  = 16,
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [TMR_W-1:0]  pause_limit,
  input  logic [TMR_W-1:0]  per_min,
  input  logic [TMR_W-1:0]  per_max,
  input  logic [GAIN_W-1:0] gain_target,
  input  logic              stat_clr,
  output logic [2:0]        fault_cause,
  output logic              fault,
  output logic              chan_mute,
  output logic              fault_irq,
  output logic              fault_stat,
  output logic [GAIN_W-1:0] gain_out,
  output logic              ramping
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [TMR_W-1:0] TMR_SAT = '1;

  function automatic logic ratio_ok(input logic [CNT_W-1:0] n);
    case (int'(n))
      32, 48, 64, 96, 128, 192, 256, 384, 512: ratio_ok = 1'b1;
      default:                                 ratio_ok = 1'b0;
    endcase
  endfunction

  // bit-clock domain: bit clocks per frame
  logic             fs_b, primed_b, tog_b;
  logic [CNT_W-1:0] bcnt, bhold;

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) begin
      fs_b     <= 1'b0;
      primed_b <= 1'b0;
      tog_b    <= 1'b0;
      bcnt     <= '0;
      bhold    <= '0;
    end else begin
      fs_b <= fsync;
      if (fsync && !fs_b) begin
        bcnt     <= CNT_W'(1);
        primed_b <= 1'b1;
        if (primed_b) begin
          bhold <= bcnt;
          tog_b <= ~tog_b;
        end
      end else if (bcnt != CNT_SAT) begin
        bcnt <= bcnt + 1'b1;
      end
    end

  // reference domain synchronisers
  logic [2:0] bs, fs, ts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bs <= '0;
      fs <= '0;
      ts <= '0;
    end else begin
      bs <= {bs[1:0], bclk};
      fs <= {fs[1:0], fsync};
      ts <= {ts[1:0], tog_b};
    end

  wire b_edge = bs[2] ^ bs[1];
  wire f_edge = fs[2] ^ fs[1];
  wire f_rise = fs[1] & ~fs[2];
  wire t_evt  = ts[2] ^ ts[1];

  // idle timers, frame period, fault causes
  logic [TMR_W-1:0] b_idle, f_idle, per_cnt;
  logic             primed_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b_idle      <= '0;
      f_idle      <= '0;
      per_cnt     <= '0;
      primed_r    <= 1'b0;
      fault_cause <= '0;
    end else begin
      b_idle <= b_edge ? '0 : (b_idle == TMR_SAT ? b_idle : b_idle + 1'b1);
      f_idle <= f_edge ? '0 : (f_idle == TMR_SAT ? f_idle : f_idle + 1'b1);
      fault_cause[2] <= (b_idle >= pause_limit) || (f_idle >= pause_limit);

      if (f_rise) begin
        per_cnt  <= TMR_W'(1);
        primed_r <= 1'b1;
        if (primed_r)
          fault_cause[0] <= (per_cnt < per_min) || (per_cnt > per_max);
      end else if (per_cnt != TMR_SAT) begin
        per_cnt <= per_cnt + 1'b1;
      end

      if (t_evt)
        fault_cause[1] <= !ratio_ok(bhold);
    end

  assign fault     = |fault_cause;
  assign chan_mute = fault;

  // gain control, event and status
  logic fault_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gain_out   <= '0;
      fault_d    <= 1'b0;
      fault_irq  <= 1'b0;
      fault_stat <= 1'b0;
    end else begin
      if (fault)
        gain_out <= '0;
      else if (gain_out > gain_target)
        gain_out <= gain_target;
      else if (f_rise && gain_out < gain_target)
        gain_out <= gain_out + 1'b1;

      fault_d   <= fault;
      fault_irq <= fault & ~fault_d;

      if (fault)
        fault_stat <= 1'b1;
      else if (stat_clr)
        fault_stat <= 1'b0;
    end

  assign ramping = !fault && (gain_out < gain_target);

endmodule

// File: rtl/asi_clk_fault_mon_chk.sv
module asi_clk_fault_mon_chk #(
  parameter int GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault,
  input logic              fault_irq,
  input logic              fault_stat,
  input logic [GAIN_W-1:0] gain_out,
  input logic [GAIN_W-1:0] gain_target
);

  // R4
  mute_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> gain_out == '0);

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_out > $past(gain_out)) |-> (gain_out == $past(gain_out) + 1'b1));

  // R6
  lower_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && gain_out > gain_target) |=> gain_out == $past(gain_target));

  // R7
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |=> fault_irq);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |=> !fault_irq);

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault_stat);

endmodule

bind asi_clk_fault_mon asi_clk_fault_mon_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault      (fault),
  .fault_irq  (fault_irq),
  .fault_stat (fault_stat),
  .gain_out   (gain_out),
  .gain_target(gain_target)
);

// File: tb/test_asi_clk_fault_mon.sv
`timescale 1ns/1ps
module test_asi_clk_fault_mon;
  logic        clk = 0, rst_n = 0, bclk = 0, fsync = 0, stat_clr = 0;
  logic [15:0] pause_limit = 16'd600, per_min = 16'd250, per_max = 16'd1100;
  logic [7:0]  gain_target = 8'd6;
  logic [2:0]  fault_cause;
  logic        fault, chan_mute, fault_irq, fault_stat, ramping;
  logic [7:0]  gain_out;

  int checks = 0, fails = 0, irq_cnt = 0, step_viol = 0;
  int cur_ratio = 64, cur_bh = 2;
  bit run = 0, gen_idle = 1;

  asi_clk_fault_mon i_asi_clk_fault_mon (
    .clk, .rst_n, .bclk, .fsync, .pause_limit, .per_min, .per_max,
    .gain_target, .stat_clr, .fault_cause, .fault, .chan_mute,
    .fault_irq, .fault_stat, .gain_out, .ramping);

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && fault_irq) irq_cnt++;

  logic [7:0] prev_gain = 0;
  always @(negedge clk) begin
    if (rst_n && gain_out > prev_gain + 8'd1) step_viol++;
    prev_gain = gain_out;
  end

  initial begin
    #3;
    forever begin
      if (!run) begin
        gen_idle = 1;
        #10;
      end else begin
        automatic int r = cur_ratio;
        automatic int h = cur_bh;
        gen_idle = 0;
        for (int i = 0; i < r; i++) begin
          bclk = 0;
          fsync = (i < r / 2);
          #(h * 10);
          bclk = 1;
          #(h * 10);
        end
      end
    end
  end

  function automatic bit exp_ratio_bad(int r);
    return !(r inside {32, 48, 64, 96, 128, 192, 256, 384, 512});
  endfunction

  function automatic bit exp_rate_bad(int r, int h, int lo, int hi);
    int p = r * 2 * h;
    return (p < lo) || (p > hi);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frames(int n);
    repeat (n) @(posedge fsync);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    int ratios[12] = '{32, 48, 64, 96, 128, 192, 256, 384, 512, 40, 80, 100};
    seed = $urandom(32'h5EED1234);

    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 gain", gain_out, 0);
    chk("R9 cause", fault_cause, 0);
    chk("R9 fault", fault, 0);
    chk("R9 irq", fault_irq, 0);
    chk("R9 stat", fault_stat, 0);

    run = 1;
    frames(10);
    chk("R1 valid ratio no fault", fault, 0);
    chk("R5 reached target", gain_out, 6);
    chk("R7 no event", irq_cnt, 0);
    chk("R8 stat clear", fault_stat, 0);

    cur_ratio = 100;
    frames(3);
    chk("R1 ratio cause", fault_cause, 3'b010);
    chk("R4 mute", chan_mute, 1);
    chk("R4 gain muted", gain_out, 0);
    chk("R7 one event", irq_cnt, 1);
    chk("R8 stat set", fault_stat, 1);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0; @(negedge clk);
    chk("R8 clear ignored during fault", fault_stat, 1);

    cur_ratio = 64;
    wait (!fault);
    frames(4);
    checks++;
    if (gain_out >= 6) begin
      fails++;
      $display("FAIL R5 ramp too fast actual=%0d expected=<6", gain_out);
    end
    chk("R5 ramping flag", ramping, 1);
    frames(6);
    chk("R5 ramp complete", gain_out, 6);
    chk("R8 stat held", fault_stat, 1);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0; @(negedge clk);
    chk("R8 stat cleared", fault_stat, 0);

    gain_target = 3;
    repeat (2) @(negedge clk);
    chk("R6 lowered target", gain_out, 3);

    gain_target = 20;
    frames(5);
    checks++;
    if (gain_out <= 3 || gain_out >= 20) begin
      fails++;
      $display("FAIL R5 mid ramp actual=%0d expected=4..19", gain_out);
    end
    cur_ratio = 100;
    frames(3);
    chk("R4 ramp aborted", gain_out, 0);
    chk("R5 not ramping in fault", ramping, 0);

    cur_ratio = 32;
    frames(3);
    chk("R2 short period cause", fault_cause, 3'b001);

    cur_ratio = 64;
    frames(3);
    chk("R2 back in range", fault_cause, 0);

    run = 0;
    wait (gen_idle);
    repeat (400) @(negedge clk);
    chk("R3 below limit", fault_cause, 0);
    repeat (100) @(negedge clk);
    chk("R3 pause cause", fault_cause, 3'b100);
    chk("R4 pause mute", gain_out, 0);
    run = 1;
    frames(4);
    chk("R3 pause cleared", fault, 0);

    pause_limit = 16'd4000;
    for (int k = 0; k < 5; k++) begin
      automatic int r = ratios[$urandom % 12];
      automatic int h = 2 + ($urandom % 2);
      automatic int e;
      cur_ratio = r;
      cur_bh = h;
      frames(3);
      e = {1'b0, exp_ratio_bad(r), exp_rate_bad(r, h, 250, 1100)};
      chk($sformatf("R1 R2 random ratio=%0d half=%0d", r, h), fault_cause, e);
      if (e != 0) chk("R4 random mute", gain_out, 0);
    end

    chk("R5 no multi-step rise", step_viol, 0);
    summary();
    $finish;
  end
endmodule